// File: doc/BRIEF.md
# Asymmetric FM Operator Datapath

This block produces one sample of an asymmetric frequency-modulation voice each time a sample tick arrives. The sample is `A * E(k_shape * cos(pm)) * sin(pc)`. Here `pm` is a modulator phase and `pc` is a carrier phase. The carrier phase is advanced by its own increment plus a deviation term, `k_dev * sin(pm)`. `E` is an exponential-shaped gain table. A host precomputes the two scale factors from the modulation index and the ratio:

- the deviation factor `k_dev = (I/2)(r+1/r)`
- the shaping factor `k_shape = (I/2)(r-1/r)`

The host supplies both factors together with the two phase increments and the amplitude.

The work runs as a short sequence of steps that all use one signed multiplier. A single table port serves three lookups: the modulator sine, the modulator cosine and the carrier sine. The exponential gain is a small computed lookup. A synchronous clear puts both phases back to zero, which restarts a note from time zero. Envelope shaping, parameter stepping over time and the converter interface belong to other blocks.

Top module: `afm_operator`

## Requirements
- R1: Reset and clear leave the outputs in a known state. After reset, `valid_o` is 0 and `sample_o` is 0. After reset or after a clear, both phase accumulators are 0, so the next sample is computed as if from time zero.
- R2: Each accepted tick advances the modulator phase by `inc_mod_i`, modulo 2^24, before any lookup for that sample. Every table read uses the top 10 phase bits as its address.
- R3: Sine table entry `a` (0..1023) is computed from `h = a mod 512` as `s = floor(524272*h*(512-h) / (1310720 - 4*h*(512-h)))`. The entry is `+s` for `a < 512` and `-s` otherwise. It is a signed 16-bit value.
- R4: The deviation is `floor(sin_m * k_dev_i / 2^7)`, taken modulo 2^24. The carrier phase becomes `pc + inc_car_i + deviation` modulo 2^24. The carrier sine is then read at the new carrier phase.
- R5: The cosine is the sine table entry at `(modulator address + 256) mod 1024`. The exponential index is `floor(cos_m * k_shape_i / 2^18)`, saturated to the range -128..127.
- R6: Exponential entry `n` (-128..127) is `(32 + (n mod 32)) << (floor(n/32) + 7)`. This is an unsigned Q4.12 value, about `4096 * 2^(n/32)`.
- R7: Two further products form the output. `shaped = floor(sin_c * E / 2^12)`. `sample_o = floor(shaped * amp_i / 2^15)` as a signed 20-bit value.
- R8: Timing of the result. A tick accepted at clock edge T gives `valid_o` high for exactly one cycle after edge T+6. `sample_o` changes only together with `valid_o` and holds its value between samples.
- R9: A tick arriving while a sample is being computed is ignored. It neither advances the phases nor produces another sample.
- R10: `clear_i` has priority over `tick_i`. It zeroes both phases and abandons any sample in progress, so no `valid_o` follows for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous phase clear and abort |
| tick_i | input | 1 | Sample tick; starts one computation when idle |
| inc_car_i | input | 24 | Carrier phase increment |
| inc_mod_i | input | 24 | Modulator phase increment |
| k_dev_i | input | 16 | Signed deviation factor |
| k_shape_i | input | 16 | Signed shaping factor |
| amp_i | input | 16 | Signed amplitude, Q1.15 |
| sample_o | output | 20 | Signed output sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench drives large positive and large negative shaping factors so that the exponential index is pushed past both ends of its range. Without saturation the index would wrap, and the gain would jump from the largest value to the smallest. Increments close to 2^24 exercise phase wrap and negative deviation. A design with a faulty quarter-period offset or faulty carrier accumulation would give wrong samples from the second tick onward. Extra ticks arriving during a computation, and clears arriving during a computation or in the same cycle as a tick, check that a busy or cleared operator neither advances its phase twice nor emits an abandoned sample.

// File: rtl/afm_pkg.sv
package afm_pkg;
  localparam int PH_W   = 24;
  localparam int ADDR_W = 10;
  localparam int D_W    = 16;
  localparam int OUT_W  = 20;

  typedef enum logic [2:0] {
    S_IDLE, S_MOD, S_CAR, S_CSIN, S_COS, S_EXP, S_AMP
  } afm_state_e;

  // Rational sine approximation over each half period
  function automatic logic signed [15:0] sine_entry(input int idx, input int addr_w);
    longint half, h, num, den, s;
    half = longint'(1) << (addr_w - 1);
    h    = longint'(idx) % half;
    num  = 32767 * 16 * h * (half - h);
    den  = 5 * half * half - 4 * h * (half - h);
    s    = num / den;
    if (idx >= half) s = -s;
    return 16'(s);
  endfunction
endpackage

// File: rtl/afm_sine_rom.sv
module afm_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int D_W    = 16
) (
  input  logic [ADDR_W-1:0]      addr_i,
  output logic signed [D_W-1:0]  data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [D_W-1:0] rom_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom_q[i] = D_W'(afm_pkg::sine_entry(i, ADDR_W));
  end

  assign data_o = rom_q[addr_i];
endmodule

// File: rtl/afm_exp_lut.sv
module afm_exp_lut #(
  parameter int IN_W   = 8,
  parameter int FRAC_W = 5,
  parameter int OUT_W  = 16,
  parameter int ONE_SH = 12
) (
  input  logic signed [IN_W-1:0] idx_i,
  output logic [OUT_W-1:0]       gain_o
);
  localparam int INT_W = IN_W - FRAC_W;
  localparam int BIAS  = ONE_SH - FRAC_W;
  localparam int SH_W  = 5;

  logic signed [INT_W-1:0] ip;
  logic [FRAC_W-1:0]       fp;
  logic [SH_W-1:0]         shamt;

  // 2^ip * (1 + fp/2^FRAC_W), scaled to Q4.12
  always_comb begin
    ip     = idx_i[IN_W-1:FRAC_W];
    fp     = idx_i[FRAC_W-1:0];
    shamt  = SH_W'(ip) + SH_W'(BIAS);
    gain_o = OUT_W'({1'b1, fp}) << shamt;
  end
endmodule

// File: rtl/afm_mul.sv
module afm_mul #(
  parameter int A_W = 21,
  parameter int B_W = 17
) (
  input  logic signed [A_W-1:0]     a_i,
  input  logic signed [B_W-1:0]     b_i,
  output logic signed [A_W+B_W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/afm_operator.sv
module afm_operator
  import afm_pkg::*;
#(
  parameter int PH_W   = afm_pkg::PH_W,
  parameter int ADDR_W = afm_pkg::ADDR_W,
  parameter int D_W    = afm_pkg::D_W,
  parameter int OUT_W  = afm_pkg::OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    tick_i,
  input  logic [PH_W-1:0]         inc_car_i,
  input  logic [PH_W-1:0]         inc_mod_i,
  input  logic signed [D_W-1:0]   k_dev_i,
  input  logic signed [D_W-1:0]   k_shape_i,
  input  logic signed [D_W-1:0]   amp_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o
);
  localparam int A_W     = OUT_W + 1;
  localparam int B_W     = D_W + 1;
  localparam int P_W     = A_W + B_W;
  localparam int DEV_SH  = 7;
  localparam int EXP_SH  = 18;
  localparam int EXP_IW  = 8;
  localparam int EXP_FW  = 5;
  localparam int ONE_SH  = 12;
  localparam int AMP_SH  = D_W - 1;
  localparam int EXP_MAX = (1 << (EXP_IW - 1)) - 1;
  localparam int EXP_MIN = -(1 << (EXP_IW - 1));
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1 << (ADDR_W - 2));

  afm_state_e state_q;
  logic [PH_W-1:0]          ph_mod_q, ph_car_q, dev_q;
  logic signed [D_W-1:0]    sin_car_q;
  logic signed [EXP_IW-1:0] exp_idx_q;
  logic signed [OUT_W-1:0]  shaped_q;

  logic [ADDR_W-1:0]        rom_addr;
  logic signed [D_W-1:0]    rom_data;
  logic [D_W-1:0]           gain;
  logic signed [A_W-1:0]    mul_a;
  logic signed [B_W-1:0]    mul_b;
  logic signed [P_W-1:0]    prod;
  logic signed [P_W-1:0]    exp_raw;
  logic signed [EXP_IW-1:0] exp_sat;

  afm_sine_rom #(.ADDR_W(ADDR_W), .D_W(D_W)) u_rom (
    .addr_i(rom_addr), .data_o(rom_data)
  );

  afm_exp_lut #(.IN_W(EXP_IW), .FRAC_W(EXP_FW), .OUT_W(D_W), .ONE_SH(ONE_SH)) u_exp (
    .idx_i(exp_idx_q), .gain_o(gain)
  );

  afm_mul #(.A_W(A_W), .B_W(B_W)) u_mul (
    .a_i(mul_a), .b_i(mul_b), .p_o(prod)
  );

  always_comb begin
    unique case (state_q)
      S_CSIN:  rom_addr = ph_car_q[PH_W-1 -: ADDR_W];
      S_COS:   rom_addr = ph_mod_q[PH_W-1 -: ADDR_W] + QUARTER;
      default: rom_addr = ph_mod_q[PH_W-1 -: ADDR_W];
    endcase
  end

  // One multiplier, operands chosen by step
  always_comb begin
    mul_a = A_W'(rom_data);
    mul_b = B_W'(k_dev_i);
    unique case (state_q)
      S_COS: mul_b = B_W'(k_shape_i);
      S_EXP: begin
        mul_a = A_W'(sin_car_q);
        mul_b = $signed({1'b0, gain});
      end
      S_AMP: begin
        mul_a = A_W'(shaped_q);
        mul_b = B_W'(amp_i);
      end
      default: ;
    endcase
  end

  always_comb begin
    exp_raw = prod >>> EXP_SH;
    if (exp_raw > $signed(P_W'(EXP_MAX)))      exp_sat = EXP_IW'(EXP_MAX);
    else if (exp_raw < $signed(P_W'(EXP_MIN))) exp_sat = EXP_IW'(EXP_MIN);
    else                                       exp_sat = exp_raw[EXP_IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ph_mod_q  <= '0;
      ph_car_q  <= '0;
      dev_q     <= '0;
      sin_car_q <= '0;
      exp_idx_q <= '0;
      shaped_q  <= '0;
      sample_o  <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        state_q  <= S_IDLE;
        ph_mod_q <= '0;
        ph_car_q <= '0;
      end else begin
        unique case (state_q)
          S_IDLE: if (tick_i) begin
            ph_mod_q <= ph_mod_q + inc_mod_i;
            state_q  <= S_MOD;
          end
          S_MOD: begin
            dev_q   <= prod[PH_W+DEV_SH-1:DEV_SH];
            state_q <= S_CAR;
          end
          S_CAR: begin
            ph_car_q <= ph_car_q + inc_car_i + dev_q;
            state_q  <= S_CSIN;
          end
          S_CSIN: begin
            sin_car_q <= rom_data;
            state_q   <= S_COS;
          end
          S_COS: begin
            exp_idx_q <= exp_sat;
            state_q   <= S_EXP;
          end
          S_EXP: begin
            shaped_q <= prod[OUT_W+ONE_SH-1:ONE_SH];
            state_q  <= S_AMP;
          end
          S_AMP: begin
            sample_o <= prod[OUT_W+AMP_SH-1:AMP_SH];
            valid_o  <= 1'b1;
            state_q  <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));

  // R9
  busy_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && !clear_i) |=> $stable(ph_mod_q));

  // R10
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ph_mod_q == '0 && ph_car_q == '0 && !valid_o && state_q == S_IDLE));

  // R2
  mod_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && tick_i && !clear_i) |=> (state_q == S_MOD));
endmodule

// File: tb/tb_afm_operator.sv
`timescale 1ns/1ps
module tb_afm_operator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, tick = 1'b0;
  logic [23:0] inc_car = '0, inc_mod = '0;
  logic signed [15:0] k_dev = '0, k_shape = '0, amp = '0;
  logic signed [19:0] sample;
  logic valid;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  longint exp_q[$];
  longint pm = 0, pc = 0;

  always #10 clk = ~clk;

  afm_operator dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .tick_i(tick),
    .inc_car_i(inc_car), .inc_mod_i(inc_mod), .k_dev_i(k_dev),
    .k_shape_i(k_shape), .amp_i(amp), .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R3 table
  function automatic longint sine_ref(input longint a);
    longint h, s;
    h = a % 512;
    s = (524272 * h * (512 - h)) / (1310720 - 4 * h * (512 - h));
    return (a < 512) ? s : -s;
  endfunction

  // R6 table
  function automatic longint exp_ref(input longint n);
    longint ip, fp;
    ip = n >>> 5;
    fp = n & 31;
    return (32 + fp) << (ip + 7);
  endfunction

  function automatic longint fdiv(input longint v, input int sh);
    return v >>> sh;
  endfunction

  function automatic longint model_step();
    longint sm, dev, sc, cm, x, e, sh;
    pm  = (pm + longint'(inc_mod)) & 64'hFFFFFF;             // R2
    sm  = sine_ref(pm >> 14);
    dev = fdiv(sm * longint'(k_dev), 7);                      // R4
    pc  = (pc + longint'(inc_car) + dev) & 64'hFFFFFF;
    sc  = sine_ref(pc >> 14);
    cm  = sine_ref(((pm >> 14) + 256) & 1023);                // R5
    x   = fdiv(cm * longint'(k_shape), 18);
    if (x > 127) x = 127;
    if (x < -128) x = -128;
    e   = exp_ref(x);
    sh  = fdiv(sc * e, 12);                                   // R7
    return fdiv(sh * longint'(amp), 15);
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9/R10: unexpected sample actual %0d expected none", sample);
      end else begin
        chk("R7 sample", longint'(sample), exp_q.pop_front());
      end
    end
  end

  task automatic one_sample(input logic [23:0] im, input logic [23:0] ic,
                            input logic signed [15:0] kd, input logic signed [15:0] ks,
                            input logic signed [15:0] a);
    bit ok;
    @(negedge clk);
    inc_mod = im; inc_car = ic; k_dev = kd; k_shape = ks; amp = a;
    exp_q.push_back(model_step());
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ok = !valid;
    repeat (5) begin @(negedge clk); ok &= !valid; end
    @(negedge clk); ok &= valid;
    @(negedge clk); ok &= !valid;
    chk("R8 latency/pulse", ok, 1);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v0;
    wait_cycles(3);
    chk("R1 valid after reset", valid, 0);
    chk("R1 sample after reset", sample, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cycles(2);
    chk("R1 valid idle", valid, 0);

    // zero phases: sin(0)=0
    one_sample(24'd0, 24'd0, 16'sd0, 16'sd0, 16'sd16384);
    // plain carrier and modulator (R2, R3, R7)
    for (int i = 0; i < 6; i++) one_sample(24'h100000, 24'h180000, 16'sd0, 16'sd0, 16'sd32767);
    // deviation and shaping (R4, R5, R6)
    for (int i = 0; i < 8; i++) one_sample(24'h0A3D71, 24'h051EB8, 16'sd12000, 16'sd5000, 16'sd20000);
    // saturation high and low (R5)
    for (int i = 0; i < 4; i++) one_sample(24'h040000, 24'h123456, 16'sd30000, 16'sd32767, 16'sd32767);
    for (int i = 0; i < 4; i++) one_sample(24'h040000, 24'h123456, -16'sd30000, -16'sd32768, -16'sd32768);
    // wrap (R2) and negative deviation (R4)
    for (int i = 0; i < 4; i++) one_sample(24'hFFFFFF, 24'hFFF000, -16'sd32768, 16'sd9000, 16'sd25000);

    // R9: tick while busy ignored
    v0 = n_valid;
    @(negedge clk);
    exp_q.push_back(model_step());
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    wait_cycles(12);
    chk("R9 one sample per busy window", n_valid - v0, 1);
    one_sample(24'hFFFFFF, 24'hFFF000, -16'sd32768, 16'sd9000, 16'sd25000);

    // R10: clear mid computation
    v0 = n_valid;
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    wait_cycles(2);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    wait_cycles(12);
    chk("R10 aborted sample", n_valid - v0, 0);
    pm = 0; pc = 0;
    one_sample(24'h0A3D71, 24'h051EB8, 16'sd12000, 16'sd5000, 16'sd20000);
    one_sample(24'h0A3D71, 24'h051EB8, 16'sd12000, 16'sd5000, 16'sd20000);

    // R10: clear beats tick in same cycle; R1 restart from zero
    v0 = n_valid;
    @(negedge clk); tick = 1'b1; clear = 1'b1;
    @(negedge clk); tick = 1'b0; clear = 1'b0;
    wait_cycles(12);
    chk("R10 clear priority", n_valid - v0, 0);
    pm = 0; pc = 0;
    one_sample(24'h100000, 24'h180000, 16'sd7000, -16'sd12000, 16'sd32767);
    one_sample(24'h100000, 24'h180000, 16'sd7000, -16'sd12000, 16'sd32767);

    wait_cycles(4);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule